// File: doc/BRIEF.md
# Strap-Guarded Watchdog Timer

This block is a watchdog timer. A host bus reads and writes it through one 8-bit control register. Software must restart the watchdog with a kick pulse before a selectable number of ticks has passed. If it does not, the block raises a reset request for exactly one cycle and starts counting again.

Two configuration straps, sampled while reset is active, choose one of three protection levels:

- **Free level:** the watchdog comes out of reset off. Turning it off needs an unlock. Its period can be rewritten at any time.
- **Guarded level:** the watchdog comes out of reset off. Both turning it off and changing its period need an unlock.
- **Locked level:** the watchdog comes out of reset running and can never be stopped. Changing its period needs an unlock.

An unlock is a single write that sets the arm bit and the run bit together. It opens a change window of four clock cycles, and the hardware closes that window by itself.

Control register fields: bits 7..5 are spare, bit 4 is arm (the change window), bit 3 is run (enable), and bits 2..0 are the period select `S`.

Top module: `wdog_guard`

## Requirements
- R1: After reset, the register reads arm=0 and select=0. Run reads 1 in the locked level and 0 in the other levels.
- R2: Bits 7..5 always read zero. Writing ones to them has no visible effect.
- R3: A write with bit 4 = 1 and bit 3 = 1 (the unlock) sets arm. Arm reads 1 for exactly four cycles and reads 0 after the fourth clock edge that follows the unlock. A later unlock restarts the four-cycle window.
- R4: A write with bit 3 = 0 clears run only if it lands on one of the four edges after an unlock. At any other time, run keeps its value.
- R5: In the guarded and locked levels, a write changes bits 2..0 only inside the change window. In the free level, bits 2..0 take the written value on every accepted write.
- R6: Strap decode, with straps given as (compat, lock): (0,0) selects the guarded level, (1,0) selects the free level, and (x,1) selects the locked level.
- R7: In the locked level, run reads 1 at all times, including after a write of bit 3 = 0 inside an open window.
- R8: A write with bit 4 = 1 and bit 3 = 0 is discarded entirely while run = 1 and the window is closed. Bits 2..0 are discarded too.
- R9: With select S, the reset request pulses high for one cycle on the 2^(BASE_LOG2+S)-th clock edge after the edge that turned run on, the last kick, or the previous pulse.
- R10: A kick sampled on a clock edge restarts the count, so the next pulse falls 2^(BASE_LOG2+S) edges after that edge.
- R11: While run is 0, the count is held at zero and no reset request is issued.
- R12: Select-bit gating on an unlock write uses the window state from before that write. Run is written as 1 by the unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register and the tick counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_compat | input | 1 | Compatibility strap, used in the level decode |
| strap_lock | input | 1 | Lock strap, forces the locked level when 1 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| kick | input | 1 | Watchdog restart pulse |
| rd_data | output | 8 | Register read value |
| rst_req | output | 1 | Single-cycle reset request |

## Verification
The bench goes after the window edges: a disable write on the fourth edge after an unlock must take effect, and the same write one edge later must not. A design with an off-by-one window counter fails one of these two cases. It also checks that a bare arm write while running is dropped together with its select bits; a design that honours the select bits there would show a changed period. The exact time-out edge is checked after both a kick and an enable, so an early or late terminal compare shows up as a pulse one cycle off. Locked-level writes of zero to run are tried inside an open window; a design that lets them through would read run as 0.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [1:0] {
    LVL_FREE   = 2'd0,
    LVL_GUARD  = 2'd1,
    LVL_LOCKED = 2'd2
  } safety_t;

  localparam int ARM_BIT = 4;
  localparam int RUN_BIT = 3;
  localparam int SEL_W   = 3;

  // Strap decode: lock strap dominates, then compat selects the free level.
  function automatic safety_t decode_safety(input logic compat, input logic lock);
    if (lock)        return LVL_LOCKED;
    else if (compat) return LVL_FREE;
    else             return LVL_GUARD;
  endfunction

  // True when the write is the unlock pattern (arm and run both set).
  function automatic logic is_unlock(input logic [7:0] d);
    return d[ARM_BIT] & d[RUN_BIT];
  endfunction

  // Bare arm write: arm set, run clear.
  function automatic logic is_bare_arm(input logic [7:0] d);
    return d[ARM_BIT] & ~d[RUN_BIT];
  endfunction

  // Select bits may change when the level is free or a window is open.
  function automatic logic sel_writable(input safety_t lvl, input logic win_open);
    return (lvl == LVL_FREE) | win_open;
  endfunction

  // Read image of the register.
  function automatic logic [7:0] pack_ctrl(input logic arm, input logic run,
                                           input logic [SEL_W-1:0] sel);
    return {3'b000, arm, run, sel};
  endfunction

endpackage

// File: rtl/wdg_window.sv
module wdg_window #(
  parameter int WIN_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  output logic open_o
);
  localparam int WW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [WW-1:0] LOAD = WW'(WIN_CYCLES - 1);

  logic [WW-1:0] left_q;
  logic          open_q;
  logic          expire;

  assign expire = open_q & (left_q == '0) & ~arm_i;
  assign open_o = open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      left_q <= '0;
    end else if (arm_i) begin
      open_q <= 1'b1;
      left_q <= LOAD;
    end else if (expire) begin
      open_q <= 1'b0;
    end else if (open_q) begin
      left_q <= left_q - 1'b1;
    end
  end

  // R3
  win_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> open_o);
  // R3
  win_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && left_q == '0 && !arm_i) |=> !open_o);
  // R3
  win_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && left_q != '0) |=> open_o);

endmodule

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
  import wdg_pkg::*;
#(
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  safety_t       level_i,
  input  logic          wr_en_i,
  input  logic [7:0]    wr_data_i,
  input  logic          win_open_i,
  output logic          unlock_o,
  output logic          run_o,
  output logic [SW-1:0] sel_o
);
  logic          run_q;
  logic [SW-1:0] sel_q;
  logic          discard_wr;
  logic          accept_wr;
  logic          run_d;
  logic [SW-1:0] sel_d;

  // Named events for the checks.
  assign unlock_o   = wr_en_i & is_unlock(wr_data_i);
  assign discard_wr = is_bare_arm(wr_data_i) & ~win_open_i & run_q;
  assign accept_wr  = wr_en_i & ~discard_wr;

  always_comb begin
    run_d = run_q;
    sel_d = sel_q;
    if (accept_wr) begin
      if (wr_data_i[RUN_BIT])  run_d = 1'b1;
      else if (win_open_i)     run_d = 1'b0;
      if (sel_writable(level_i, win_open_i)) sel_d = wr_data_i[SW-1:0];
    end
    if (level_i == LVL_LOCKED) run_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= (level_i == LVL_LOCKED);
      sel_q <= '0;
    end else begin
      run_q <= run_d;
      sel_q <= sel_d;
    end
  end

  assign run_o = run_q;
  assign sel_o = sel_q;

  // R4
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !win_open_i && run_o) |=> run_o);
  // R5
  sel_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !win_open_i && level_i != LVL_FREE) |=> $stable(sel_o));
  // R7
  locked_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_i == LVL_LOCKED) |-> run_o);
  // R8
  bare_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && is_bare_arm(wr_data_i) && !win_open_i && run_o) |=> $stable(sel_o));
  // R12
  unlock_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_o |=> run_o);

endmodule

// File: rtl/wdg_tick_counter.sv
module wdg_tick_counter #(
  parameter int BASE_LOG2 = 14,
  parameter int SW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          kick_i,
  input  logic [SW-1:0] sel_i,
  output logic          req_o
);
  localparam int MAX_SEL = (1 << SW) - 1;
  localparam int CNT_W   = BASE_LOG2 + MAX_SEL;

  // Last count value before wrap: 2^(BASE_LOG2+sel) - 1.
  function automatic logic [CNT_W-1:0] last_tick(input logic [SW-1:0] sel);
    return {CNT_W{1'b1}} >> (MAX_SEL - int'(sel));
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             req_q;
  logic             terminal;

  assign terminal = run_i & ~kick_i & (cnt_q >= last_tick(sel_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= terminal;
      if (!run_i || kick_i || terminal) cnt_q <= '0;
      else                              cnt_q <= cnt_q + 1'b1;
    end
  end

  assign req_o = req_q;

  // R9
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);
  // R10
  kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> (cnt_q == '0 && !req_o));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0 && !req_o));

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdg_pkg::*;
#(
  parameter int BASE_LOG2  = 14,
  parameter int WIN_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_compat,
  input  logic       strap_lock,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       kick,
  output logic [7:0] rd_data,
  output logic       rst_req
);
  safety_t            level;
  logic               unlock;
  logic               win_open;
  logic               run;
  logic [SEL_W-1:0]   sel;

  assign level = decode_safety(strap_compat, strap_lock);

  wdg_window #(.WIN_CYCLES(WIN_CYCLES)) win_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm_i  (unlock),
    .open_o (win_open)
  );

  wdg_ctrl_reg #(.SW(SEL_W)) reg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .level_i    (level),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .win_open_i (win_open),
    .unlock_o   (unlock),
    .run_o      (run),
    .sel_o      (sel)
  );

  wdg_tick_counter #(.BASE_LOG2(BASE_LOG2), .SW(SEL_W)) cnt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .kick_i (kick),
    .sel_i  (sel),
    .req_o  (rst_req)
  );

  assign rd_data = pack_ctrl(win_open, run, sel);

  // R2
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[7:5] == 3'b000));
  // R11
  no_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run)) |-> !rst_req);

endmodule

// File: tb/wdog_guard_tb_top.sv
module wdog_guard_tb_top;
  localparam int BASE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap_compat = 1'b0;
  logic       strap_lock = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       kick = 1'b0;
  logic [7:0] rd_data;
  logic       rst_req;

  always #5 clk = ~clk;

  wdog_guard #(.BASE_LOG2(BASE), .WIN_CYCLES(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .strap_compat(strap_compat), .strap_lock(strap_lock),
    .wr_en(wr_en), .wr_data(wr_data), .kick(kick), .rd_data(rd_data), .rst_req(rst_req)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Bench model state.
  int       lvl;
  bit       m_arm, m_run, m_req;
  bit [2:0] m_sel;
  int       m_left, m_age;

  function automatic int period(input int s);
    int v = 1;
    for (int i = 0; i < BASE + s; i++) v = v * 2;
    return v;
  endfunction

  function automatic int level_of(input bit c, input bit l);
    if (l) return 2;
    return c ? 0 : 1;
  endfunction

  function automatic bit [7:0] image();
    return {3'b000, m_arm, m_run, m_sel};
  endfunction

  task automatic compare(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit a0, r0;
    int left0;
    a0 = m_arm; r0 = m_run; left0 = m_left;
    m_req = 0;
    if (!r0 || kick) m_age = 0;
    else if (m_age + 1 >= period(m_sel)) begin m_age = 0; m_req = 1; end
    else m_age = m_age + 1;
    if (wr_en && wr_data[4] && wr_data[3]) begin m_arm = 1; m_left = 3; end
    else if (a0) begin
      if (left0 == 0) m_arm = 0; else m_left = left0 - 1;
    end
    if (wr_en && !(wr_data[4] && !wr_data[3] && !a0 && r0)) begin
      if (wr_data[3]) m_run = 1;
      else if (a0) m_run = 0;
      if (lvl == 0 || a0) m_sel = wr_data[2:0];
    end
    if (lvl == 2) m_run = 1;
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare("R2/R3/R4/R5/R7/R8/R12 rd_data", rd_data, image());
    compare("R9/R10/R11 rst_req", rst_req, m_req);
    wr_en = 0;
    kick = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input bit [7:0] v);
    wr_data = v;
    wr_en = 1;
    tick();
  endtask

  task automatic do_reset(input bit c, input bit l);
    @(negedge clk);
    rst_n = 0; wr_en = 0; kick = 0;
    strap_compat = c; strap_lock = l;
    lvl = level_of(c, l);
    m_arm = 0; m_run = (lvl == 2); m_sel = 0; m_left = 0; m_age = 0; m_req = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset rd_data", rd_data, image());
    compare("R1 reset rst_req", rst_req, 0);
    rst_n = 1;
  endtask

  initial begin
    void'($urandom(32'd1234));

    // Guarded level.
    do_reset(0, 0);
    compare("R1 R6 guarded reset", rd_data, 8'h00);
    wr(8'hFF);
    compare("R2 R12 unlock with spare bits", rd_data, 8'h18);
    wr(8'h05);
    compare("R4 R5 write in window", rd_data, 8'h15);
    idle(4);
    compare("R3 window closed", rd_data, 8'h05);
    wr(8'h08);
    compare("R5 select locked outside window", rd_data, 8'h0D);
    wr(8'h00);
    compare("R4 disable refused", rd_data, 8'h0D);
    wr(8'h12);
    compare("R8 bare arm discarded", rd_data, 8'h0D);
    kick = 1; tick();
    idle(511);
    compare("R9 no pulse before period", rst_req, 0);
    idle(1);
    compare("R9 pulse at period", rst_req, 1);
    idle(1);
    compare("R9 pulse one cycle", rst_req, 0);
    idle(300);
    kick = 1; tick();
    idle(511);
    compare("R10 kick delays pulse", rst_req, 0);
    idle(1);
    compare("R10 pulse after kick", rst_req, 1);
    wr(8'h1D);
    compare("R3 unlock sets arm", rd_data, 8'h1D);
    idle(3);
    compare("R3 arm still open", rd_data, 8'h1D);
    wr(8'h05);
    compare("R4 disable on fourth edge", rd_data, 8'h05);
    wr(8'h0D);
    wr(8'h1D);
    idle(4);
    compare("R3 arm closed after four", rd_data, 8'h0D);
    wr(8'h05);
    compare("R4 disable on fifth edge refused", rd_data, 8'h0D);
    wr(8'h1D);
    wr(8'h05);
    idle(1100);
    compare("R11 no pulse while off", rst_req, 0);

    // Free level.
    do_reset(1, 0);
    compare("R1 R6 free reset", rd_data, 8'h00);
    wr(8'h03);
    compare("R5 R6 free select", rd_data, 8'h03);
    wr(8'h0B);
    wr(8'h02);
    compare("R4 R5 free select, disable refused", rd_data, 8'h0A);

    // Locked level.
    do_reset(0, 1);
    compare("R1 R7 locked reset", rd_data, 8'h08);
    wr(8'h19);
    compare("R5 R12 locked unlock keeps select", rd_data, 8'h18);
    wr(8'h01);
    compare("R7 locked run stays", rd_data, 8'h19);
    do_reset(1, 1);
    compare("R6 compat+lock is locked", rd_data, 8'h08);

    // Constrained random phases on every strap pair.
    for (int p = 0; p < 4; p++) begin
      do_reset(p[0], p[1]);
      for (int i = 0; i < 15000; i++) begin
        int r;
        bit [7:0] s;
        r = $urandom;
        s = 8'($urandom % 4);
        kick = ((r % 97) == 0);
        if ((r % 13) == 0) begin
          wr_en = 1;
          case ($urandom % 4)
            0: wr_data = 8'h18 | s;
            1: wr_data = s;
            2: wr_data = 8'h10 | s;
            default: wr_data = 8'($urandom);
          endcase
        end
        tick();
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired R1 actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule